// File: doc/BRIEF.md
# Serial Input Fine Phase Aligner

This block sits at the receive end of a low-speed serial input and picks the sampling phase for each bit. A delay line gives fifteen taps at one-eighth of a bit apart, so all taps together span 7/4 of a bit. Here it is modelled as a word of fifteen samples per bit slot: sample `i` is the line seen through `i` delay steps. The block chooses one tap and sends the bit seen there out as a one-bit stream. It corrects only the phase within a bit. Whole-bit slips are left to the logic downstream.

The tap can be chosen in three ways. In static mode it comes straight from an input. In automatic mode an edge histogram is built over every 64-bit window, and the tap is moved to the side of the bit opposite the most common edge position. This tracking stays inside the middle taps and, once it has settled, stays close to its first choice. In trained mode one histogram window runs after a train pulse, and the tap it yields is then held until the next pulse, so the value can be read out and reused. The line rate is selected among 40, 80, 160 and 320 Mb/s. At lower rates each bit occupies several input words, and only the first word of each bit is used.

Both data sides use valid/ready. An input word is taken when `s_valid` and `s_ready` are both high. `s_ready` is low while an output bit is waiting and `m_ready` is low, and it is also low for the one cycle in which a new rate selection takes effect. An output bit stays on `m_bit`, unchanged and with `m_valid` high, until `m_ready` accepts it.

Top module: `fine_phase_aligner`

## Requirements
- R1: After reset `m_valid` and `locked` are low, `s_ready` is high, and in static mode `sel_tap` shows the static tap value.
- R2: Mode code 0 (and code 3) is static. `sel_tap` equals `static_tap`, with 15 reduced to 14, and `locked` stays low. Each output bit is `s_taps[sel_tap]`, where a higher bit index is a longer delay.
- R3: With `rate_sel` code k (0 = 40, 1 = 80, 2 = 160, 3 = 320 Mb/s), one output bit is produced for every 2^(3-k) accepted words, taken from the first word of each group. A change of `rate_sel` restarts the grouping and holds `s_ready` low for one cycle.
- R4: While `m_valid` is high and `m_ready` is low, `m_valid` stays high, `m_bit` does not change and `s_ready` is low.
- R5: An edge at position p (1 to 14) is counted when `s_taps[p]` differs from `s_taps[p-1]`, on the first word of each bit only. After 64 bits the dominant position e is taken, the lowest one on a tie. The target tap is then e+4 if e < 8 and e-4 otherwise.
- R6: A window with fewer than 16 counted edges drives `locked` low and leaves the tap unchanged. Lock is only declared after a window that has at least 16 edges.
- R7: Mode code 1 is automatic. Windows run back to back, and the tap always stays between 4 and 11.
- R8: In automatic mode the first window with enough edges sets the tap and records it as an anchor. Every later target is clipped to the anchor ±3, kept inside 4 to 11.
- R9: Mode code 2 is trained. A one-cycle `train` pulse starts a single 64-bit window. At its end the target tap is latched and `locked` goes high.
- R10: In trained mode, data arriving after the training window changes neither `sel_tap` nor `locked` until the next `train` pulse.
- R11: A change of mode sets the held tap to 7, clears `locked` and restarts the histogram window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one input word per cycle at most |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 static, 1 automatic, 2 trained, 3 static |
| static_tap | input | 4 | Tap used in static mode |
| rate_sel | input | 2 | Line rate code, 0 = 40 to 3 = 320 Mb/s |
| train | input | 1 | One-cycle pulse that starts a training window |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block can accept an input word |
| s_taps | input | 15 | Samples of the line, one for each delay tap |
| m_valid | output | 1 | Recovered bit valid |
| m_ready | input | 1 | Consumer accepts the recovered bit |
| m_bit | output | 1 | Recovered bit |
| sel_tap | output | 4 | Tap currently in use |
| locked | output | 1 | Alignment found from enough edges |

## Verification
Some rules are checked on every cycle. The automatic tap never leaves taps 4 to 11 and never moves more than three taps from its anchor. A stalled output bit does not change. A trained tap is not touched by incoming data. Static mode never reports lock. Lock only rises after a window with enough edges. A mode change resets the held tap. Other behaviour can only be shown by the bench scenarios: the exact centre chosen for each edge position, the 16-edge threshold on both sides, the bit count at each rate, and the bit value seen through each static tap.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef enum logic [1:0] {
    PA_STATIC  = 2'd0,
    PA_AUTO    = 2'd1,
    PA_TRAINED = 2'd2,
    PA_RSVD    = 2'd3
  } pa_mode_e;

  // Tap facing the dominant edge: half a bit away, staying inside the line.
  function automatic int centre_of(input int pos, input int slots);
    return (pos < slots) ? pos + slots / 2 : pos - slots / 2;
  endfunction

  function automatic int clip(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/pa_sampler.sv
module pa_sampler #(
  parameter int N_TAPS = 15,
  parameter int TAP_W  = 4,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [TAP_W-1:0]  tap,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [N_TAPS-1:0] s_taps,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_bit,
  output logic              ev,
  output logic [N_TAPS-1:0] ev_word
);
  localparam int PH_W = (2 ** RATE_W) - 1;

  logic [RATE_W-1:0] rate_q;
  logic [PH_W-1:0]   ph;
  logic [PH_W-1:0]   ph_mask;
  logic              accept;

  assign ph_mask = {PH_W{1'b1}} >> rate_sel;
  assign s_ready = (!m_valid || m_ready) && (rate_sel == rate_q);
  assign accept  = s_valid && s_ready;
  assign ev      = accept && (ph == '0);
  assign ev_word = s_taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      ph     <= '0;
    end else if (rate_sel != rate_q) begin
      rate_q <= rate_sel;
      ph     <= '0;
    end else if (accept) begin
      ph <= (ph + 1'b1) & ph_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_bit   <= 1'b0;
    end else if (ev) begin
      m_valid <= 1'b1;
      m_bit   <= s_taps[tap];
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_bit)))
    else $error("stalled output bit changed"); // R4

  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !accept)
    else $error("word taken during stall"); // R4

endmodule

// File: rtl/pa_edge_hist.sv
module pa_edge_hist #(
  parameter int N_TAPS    = 15,
  parameter int WIN_BITS  = 64,
  parameter int MIN_EDGES = 16,
  parameter int PW        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ev,
  input  logic [N_TAPS-1:0] word,
  output logic              res_v,
  output logic [PW-1:0]     res_pos,
  output logic              res_enough
);
  localparam int CW    = $clog2(WIN_BITS + 1);
  localparam int WCW   = $clog2(WIN_BITS);
  localparam int MAXT  = (N_TAPS - 1) * WIN_BITS;
  localparam int TW    = $clog2(MAXT + 1);

  logic [N_TAPS-1:1] edg;
  logic [CW-1:0]     cnt [1:N_TAPS-1];
  logic [CW-1:0]     nxt [1:N_TAPS-1];
  logic [WCW-1:0]    wcnt;
  logic [TW-1:0]     total;
  logic [TW-1:0]     total_nxt;
  logic              done;
  logic [PW-1:0]     best_p;
  logic [CW-1:0]     best_v;

  assign done = ev && !clr && (wcnt == WCW'(WIN_BITS - 1));

  for (genvar p = 1; p < N_TAPS; p++) begin : g_pos
    assign edg[p] = word[p] ^ word[p-1];
    assign nxt[p] = cnt[p] + CW'(ev && edg[p]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt[p] <= '0;
      else if (clr || done) cnt[p] <= '0;
      else                  cnt[p] <= nxt[p];
    end
  end

  always_comb begin
    total_nxt = total;
    for (int p = 1; p < N_TAPS; p++) total_nxt = total_nxt + TW'(ev && edg[p]);
  end

  always_comb begin
    best_p = PW'(1);
    best_v = nxt[1];
    for (int p = 2; p < N_TAPS; p++) begin
      if (nxt[p] > best_v) begin
        best_v = nxt[p];
        best_p = PW'(p);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt  <= '0;
      total <= '0;
    end else if (clr || done) begin
      wcnt  <= '0;
      total <= '0;
    end else begin
      total <= total_nxt;
      if (ev) wcnt <= wcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_v      <= 1'b0;
      res_pos    <= '0;
      res_enough <= 1'b0;
    end else begin
      res_v <= done;
      if (done) begin
        res_pos    <= best_p;
        res_enough <= (int'(total_nxt) >= MIN_EDGES);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(total) <= MAXT)
    else $error("edge total beyond window capacity"); // R5

  AST_RESULT_POS: assert property (@(posedge clk) disable iff (!rst_n)
    res_v |-> (int'(res_pos) >= 1 && int'(res_pos) < N_TAPS))
    else $error("edge position out of line"); // R5

endmodule

// File: rtl/pa_tap_ctrl.sv
module pa_tap_ctrl
  import pa_pkg::*;
#(
  parameter int N_TAPS    = 15,
  parameter int TAP_W     = 4,
  parameter int BIT_SLOTS = 8,
  parameter int AUTO_LO   = 4,
  parameter int AUTO_HI   = 11,
  parameter int WANDER    = 3,
  parameter int TAP_INIT  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [TAP_W-1:0] static_tap,
  input  logic             train,
  input  logic             res_v,
  input  logic [TAP_W-1:0] res_pos,
  input  logic             res_enough,
  output logic [TAP_W-1:0] sel_tap,
  output logic             locked,
  output logic             hist_clr
);
  pa_mode_e         eff;
  pa_mode_e         mode_q;
  logic [TAP_W-1:0] tap_q;
  logic [TAP_W-1:0] anchor;
  logic             settled;
  logic             training;
  logic             locked_q;
  int               tgt;
  int               lo_b;
  int               hi_b;
  int               wander_tgt;
  int               stat_tap;

  always_comb begin
    case (mode)
      2'd1:    eff = PA_AUTO;
      2'd2:    eff = PA_TRAINED;
      default: eff = PA_STATIC;
    endcase
  end

  always_comb begin
    tgt        = clip(centre_of(int'(res_pos), BIT_SLOTS), AUTO_LO, AUTO_HI);
    lo_b       = (int'(anchor) - WANDER < AUTO_LO) ? AUTO_LO : int'(anchor) - WANDER;
    hi_b       = (int'(anchor) + WANDER > AUTO_HI) ? AUTO_HI : int'(anchor) + WANDER;
    wander_tgt = clip(tgt, lo_b, hi_b);
    stat_tap   = clip(int'(static_tap), 0, N_TAPS - 1);
  end

  assign hist_clr = (eff != mode_q) || (eff == PA_TRAINED && mode_q == PA_TRAINED && train);
  assign sel_tap  = (eff == PA_STATIC) ? TAP_W'(stat_tap) : tap_q;
  assign locked   = locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PA_STATIC;
      tap_q    <= TAP_W'(TAP_INIT);
      anchor   <= TAP_W'(TAP_INIT);
      settled  <= 1'b0;
      training <= 1'b0;
      locked_q <= 1'b0;
    end else if (eff != mode_q) begin
      mode_q   <= eff;
      tap_q    <= TAP_W'(TAP_INIT);
      settled  <= 1'b0;
      training <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      case (mode_q)
        PA_AUTO: begin
          if (res_v) begin
            if (res_enough) begin
              locked_q <= 1'b1;
              if (!settled) begin
                tap_q   <= TAP_W'(tgt);
                anchor  <= TAP_W'(tgt);
                settled <= 1'b1;
              end else begin
                tap_q <= TAP_W'(wander_tgt);
              end
            end else begin
              locked_q <= 1'b0;
            end
          end
        end
        PA_TRAINED: begin
          if (train) begin
            training <= 1'b1;
            locked_q <= 1'b0;
          end else if (res_v && training) begin
            training <= 1'b0;
            if (res_enough) begin
              tap_q    <= TAP_W'(tgt);
              locked_q <= 1'b1;
            end else begin
              locked_q <= 1'b0;
            end
          end
        end
        default: locked_q <= 1'b0;
      endcase
    end
  end

  AST_AUTO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PA_AUTO) |-> (int'(tap_q) >= AUTO_LO && int'(tap_q) <= AUTO_HI))
    else $error("automatic tap left middle window"); // R7

  AST_WANDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PA_AUTO && settled) |->
      (int'(tap_q) >= int'(anchor) - WANDER && int'(tap_q) <= int'(anchor) + WANDER))
    else $error("automatic tap strayed from anchor"); // R8

  AST_TRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PA_TRAINED && eff == PA_TRAINED && !training && !train) |=>
      ($stable(tap_q) && $stable(locked_q)))
    else $error("trained tap moved without a train pulse"); // R10

  AST_STATIC_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PA_STATIC) |-> !locked_q)
    else $error("lock reported in static mode"); // R2

  AST_LOCK_NEEDS_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(res_v && res_enough))
    else $error("lock without a window of edges"); // R6

  AST_MODE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (eff != mode_q) |=> (tap_q == TAP_W'(TAP_INIT) && !locked_q))
    else $error("mode change did not reset the tap"); // R11

endmodule

// File: rtl/fine_phase_aligner.sv
module fine_phase_aligner #(
  parameter int N_TAPS    = 15,
  parameter int TAP_W     = 4,
  parameter int RATE_W    = 2,
  parameter int BIT_SLOTS = 8,
  parameter int WIN_BITS  = 64,
  parameter int MIN_EDGES = 16,
  parameter int AUTO_LO   = 4,
  parameter int AUTO_HI   = 11,
  parameter int WANDER    = 3,
  parameter int TAP_INIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [TAP_W-1:0]  static_tap,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              train,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [N_TAPS-1:0] s_taps,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_bit,
  output logic [TAP_W-1:0]  sel_tap,
  output logic              locked
);
  logic              ev;
  logic [N_TAPS-1:0] ev_word;
  logic              hist_clr;
  logic              res_v;
  logic [TAP_W-1:0]  res_pos;
  logic              res_enough;

  pa_sampler #(
    .N_TAPS(N_TAPS), .TAP_W(TAP_W), .RATE_W(RATE_W)
  ) i_sampler (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tap(sel_tap),
    .s_valid(s_valid), .s_ready(s_ready), .s_taps(s_taps),
    .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit),
    .ev(ev), .ev_word(ev_word)
  );

  pa_edge_hist #(
    .N_TAPS(N_TAPS), .WIN_BITS(WIN_BITS), .MIN_EDGES(MIN_EDGES), .PW(TAP_W)
  ) i_hist (
    .clk(clk), .rst_n(rst_n), .clr(hist_clr), .ev(ev), .word(ev_word),
    .res_v(res_v), .res_pos(res_pos), .res_enough(res_enough)
  );

  pa_tap_ctrl #(
    .N_TAPS(N_TAPS), .TAP_W(TAP_W), .BIT_SLOTS(BIT_SLOTS),
    .AUTO_LO(AUTO_LO), .AUTO_HI(AUTO_HI), .WANDER(WANDER), .TAP_INIT(TAP_INIT)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .static_tap(static_tap),
    .train(train), .res_v(res_v), .res_pos(res_pos), .res_enough(res_enough),
    .sel_tap(sel_tap), .locked(locked), .hist_clr(hist_clr)
  );

endmodule

// File: tb/test_fine_phase_aligner.sv
module test_fine_phase_aligner;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  static_tap = 4'd0;
  logic [1:0]  rate_sel = 2'd3;
  logic        train = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [14:0] s_taps = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic        m_bit;
  logic [3:0]  sel_tap;
  logic        locked;

  int   n_chk = 0;
  int   n_bad = 0;
  int   out_cnt = 0;
  int   wr = 0;
  int   rd = 0;
  int   exp_tap = 0;
  bit   chk_bits = 1'b0;
  bit   finished = 1'b0;
  logic last_bit = 1'b0;
  logic exp_bits [0:255];

  always #(CLK_P/2) clk = ~clk;

  fine_phase_aligner i_fine_phase_aligner (
    .clk(clk), .rst_n(rst_n), .mode(mode), .static_tap(static_tap),
    .rate_sel(rate_sel), .train(train), .s_valid(s_valid), .s_ready(s_ready),
    .s_taps(s_taps), .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit),
    .sel_tap(sel_tap), .locked(locked)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int centre(input int e);
    return (e < 8) ? e + 4 : e - 4;
  endfunction

  function automatic int lim(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // monitor: every accepted output bit is counted and, when enabled, compared
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      out_cnt++;
      if (chk_bits) begin
        check("R2 bit via tap", int'(m_bit), int'(exp_bits[rd % 256]));
        rd++;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_word(input logic [14:0] w);
    s_valid = 1'b1;
    s_taps  = w;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1;
    s_valid = 1'b0;
  endtask

  // one line bit: edge between taps e-1 and e, lower taps see the new value
  task automatic send_bit(input int e, input logic cur);
    logic [14:0] w;
    int rep;
    rep = 8 >> rate_sel;
    for (int i = 0; i < 15; i++) w[i] = (i < e) ? cur : last_bit;
    if (chk_bits) begin
      exp_bits[wr % 256] = (exp_tap < e) ? cur : last_bit;
      wr++;
    end
    for (int r = 0; r < rep; r++) send_word(w);
    last_bit = cur;
  endtask

  task automatic send_window(input int e);
    for (int k = 0; k < 64; k++) send_bit(e, ~last_bit);
  endtask

  task automatic pulse_train();
    train = 1'b1;
    idle(1);
    train = 1'b0;
    idle(1);
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode = m;
    idle(3);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int a;
    int cnt0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check("R1 m_valid", int'(m_valid), 0);
    check("R1 locked", int'(locked), 0);
    check("R1 s_ready", int'(s_ready), 1);
    check("R1 sel_tap", int'(sel_tap), 0);

    // R2 static sweep over every tap code, bits checked in the monitor
    chk_bits = 1'b1;
    for (int t = 0; t < 16; t++) begin
      static_tap = 4'(t);
      exp_tap = lim(t, 0, 14);
      idle(1);
      check("R2 static sel_tap", int'(sel_tap), exp_tap);
      for (int k = 0; k < 4; k++) send_bit(5, ~last_bit);
      idle(2);
      check("R2 static locked", int'(locked), 0);
    end

    // R3 rate sweep: one output per 2^(3-k) words
    static_tap = 4'd9;
    exp_tap = 9;
    for (int r = 0; r < 4; r++) begin
      rate_sel = 2'(r);
      idle(2);
      cnt0 = out_cnt;
      for (int k = 0; k < 8; k++) send_bit(6, ~last_bit);
      idle(3);
      check("R3 outputs per rate", out_cnt - cnt0, 8);
    end

    // R4 back-pressure
    m_ready = 1'b0;
    send_bit(12, ~last_bit);
    for (int k = 0; k < 4; k++) begin
      check("R4 m_valid held", int'(m_valid), 1);
      check("R4 s_ready low", int'(s_ready), 0);
      check("R4 m_bit held", int'(m_bit), int'(exp_bits[(wr - 1) % 256]));
      idle(1);
    end
    m_ready = 1'b1;
    idle(3);
    check("R4 drained", int'(m_valid), 0);
    chk_bits = 1'b0;

    // R9 / R5 trained sweep over every edge position
    set_mode(2'd2);
    check("R11 trained entry tap", int'(sel_tap), 7);
    for (int e = 1; e < 15; e++) begin
      pulse_train();
      send_window(e);
      idle(4);
      check("R9 R5 trained tap", int'(sel_tap), centre(e));
      check("R9 trained locked", int'(locked), 1);
    end

    // R6 threshold: 15 edges fail, 16 edges pass
    pulse_train();
    for (int k = 0; k < 64; k++) send_bit(2, (k >= 1 && k <= 15) ? ~last_bit : last_bit);
    idle(4);
    check("R6 15 edges unlocked", int'(locked), 0);
    check("R6 15 edges tap kept", int'(sel_tap), centre(14));
    pulse_train();
    for (int k = 0; k < 64; k++) send_bit(2, (k >= 1 && k <= 16) ? ~last_bit : last_bit);
    idle(4);
    check("R6 16 edges locked", int'(locked), 1);
    check("R6 16 edges tap", int'(sel_tap), centre(2));

    // R10 later data ignored without a train pulse
    send_window(12);
    idle(4);
    check("R10 trained tap held", int'(sel_tap), centre(2));
    check("R10 trained lock held", int'(locked), 1);

    // R11 + R7/R8 automatic sessions with two anchors
    for (int s = 0; s < 2; s++) begin
      set_mode(2'd0);
      set_mode(2'd1);
      check("R11 auto entry tap", int'(sel_tap), 7);
      check("R11 auto entry lock", int'(locked), 0);
      send_window(s == 0 ? 13 : 2);
      idle(4);
      a = centre(s == 0 ? 13 : 2);
      check("R8 anchor tap", int'(sel_tap), a);
      check("R8 anchor lock", int'(locked), 1);
      for (int e = 1; e < 15; e++) begin
        send_window(e);
        idle(4);
        check("R7 R8 auto tap", int'(sel_tap), lim(centre(e), lim(a - 3, 4, 11), lim(a + 3, 4, 11)));
      end
    end

    // R6 no transitions in automatic mode
    a = int'(sel_tap);
    for (int k = 0; k < 64; k++) send_bit(3, last_bit);
    idle(4);
    check("R6 quiet unlocked", int'(locked), 0);
    check("R6 quiet tap kept", int'(sel_tap), a);
    send_window(6);
    idle(4);
    check("R6 relock", int'(locked), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule